// File: doc/BRIEF.md
# IN Endpoint Buffer Status Tracker

This block tracks how full the transmit buffer of one bulk or interrupt IN endpoint is inside a USB device controller. The CPU fills the endpoint buffer one byte or one 16-bit word at a time. It then declares the data ready with a set-ready strobe. The protocol engine asks for the length and start address of the oldest pending packet and reports each packet the host acknowledged. From these events the block keeps a 2-bit status code, the CPU write address, and the read position of the packet to transmit next.

The buffer region begins at a programmable base address. Its size is a programmable number of 64-byte units, up to 1024 bytes. In double-buffer mode a second region of the same size follows the first, so the CPU can load one packet while the other is being sent. In continuous mode the whole region holds one data set, which is sent as packets of max-packet size, with a short packet at the end if one is needed. With auto-set enabled, a buffer that fills to a full packet (or, in continuous mode, to a full region) is declared ready without a CPU strobe. The memory array and the packet serialiser sit outside this block.

Top module: `inep_buf_tracker`

## Requirements
- R1: While `ep_en` is low, including after reset, `sts` reads 11. On the first clock edge at which `ep_en` is high, `sts` becomes 00 and `wr_addr` returns to `base_addr`.
- R2: A CPU write is taken only while `sts[1]` is 0. Each write that is taken advances `wr_addr` by 2 when `word_mode` is 1 and by 1 otherwise. Writes made while `sts[1]` is 1 leave `wr_addr` unchanged.
- R3: The region size is (`buf_units`+1)×64 bytes. The write offset stops at the region size. In double-buffer mode the second region starts at `base_addr` plus the region size.
- R4: In single-buffer mode (`dbl_buf`=0, `cont_mode`=0), set-ready moves `sts` from 00 to 11 and `tx_ack` moves it from 11 to 00.
- R5: In double-buffer mode, set-ready moves `sts` from 00 to 01 and from 01 to 11. `tx_ack` moves it from 11 to 01 and from 01 to 00. Packets are sent in the order they were loaded, alternating between the two regions.
- R6: A set-ready while `sts` is 11 is ignored: the status, the write address and the stored packet lengths do not change.
- R7: A `tx_ack` while `sts` is 00 is ignored.
- R8: In continuous mode the status uses the single-buffer codes whatever `dbl_buf` is set to. Each packet has length min(remaining, `maxp`), and its address advances by `maxp` after each acknowledgement. `sts` returns to 00 only when the last packet of the data set is acknowledged. An empty data set is sent as one zero-length packet.
- R9: With `auto_set`=1, a write that brings the buffered byte count to `maxp` (or to the region size in continuous mode) acts as set-ready in that same cycle. A shorter fill still needs an explicit `set_rdy`.
- R10: The cycle after `pkt_req`, `pkt_vld` is 1 only if the endpoint is enabled and `sts` is not 00. `pkt_len` and `pkt_addr` then give the oldest pending packet.
- R11: In double-buffer mode, a set-ready and a `tx_ack` in the same cycle at status 01 leave the status at 01. The newly loaded packet becomes the next one to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_en | input | 1 | Endpoint enable |
| dbl_buf | input | 1 | Double-buffer mode select |
| cont_mode | input | 1 | Continuous (bulk data set) mode select |
| auto_set | input | 1 | Automatic set-ready on a full packet or full region |
| word_mode | input | 1 | 1: CPU writes are 16-bit words; 0: bytes |
| buf_units | input | UNIT_W | Region size in 64-byte units, minus one |
| base_addr | input | ADDR_W | Start address of the buffer region |
| maxp | input | LEN_W | Maximum packet size in bytes |
| cpu_wr | input | 1 | CPU write strobe to the FIFO data register |
| set_rdy | input | 1 | CPU set-ready strobe |
| tx_ack | input | 1 | Host acknowledged the current packet |
| pkt_req | input | 1 | Protocol engine requests the next packet descriptor |
| sts | output | 2 | Buffer status code |
| wr_addr | output | ADDR_W | Address of the next CPU write |
| pkt_vld | output | 1 | Packet descriptor valid |
| pkt_len | output | LEN_W | Length of the pending packet |
| pkt_addr | output | ADDR_W | Start address of the pending packet |

## Verification
The bench sweeps fill lengths from zero up to past the region size. This catches a write offset that does not stop at the region end, which would make `wr_addr` run into the next region, and a missing zero-length packet. In continuous mode it tries max-packet sizes that divide the data set evenly and sizes that do not. A design that mishandles the remainder would either hang at status 11 or return to 00 one packet early, and the per-packet length and address checks show both. The double-buffer runs load, send and reload in an interleaved order and issue set-ready and acknowledge in the same cycle. A swapped region select or a lost update there shows up as the wrong length or address in the next descriptor. Ignored strobes at 11 and 00 are followed by a descriptor read, so a stored length overwritten by a set-ready that should have been ignored is also caught.

// File: rtl/inep_pkg.sv
package inep_pkg;
  typedef enum logic [1:0] {
    BS_EMPTY = 2'b00,
    BS_ONE   = 2'b01,
    BS_FULL  = 2'b11
  } bsts_e;

  // count of loaded packets -> status code
  function automatic bsts_e code_of(input logic [1:0] cnt, input logic dbl);
    if (cnt == 2'd0)      return BS_EMPTY;
    else if (cnt == 2'd1) return dbl ? BS_ONE : BS_FULL;
    else                  return BS_FULL;
  endfunction
endpackage

// File: rtl/inep_wrptr.sv
module inep_wrptr #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_acc,
  input  logic             word_mode,
  input  logic [LEN_W-1:0] bsz,
  input  logic             set_take,
  input  logic             dbl,
  output logic [LEN_W-1:0] wr_ofs,
  output logic [LEN_W-1:0] wr_ofs_nxt,
  output logic             wr_sel
);
  logic [LEN_W:0] sum;

  always_comb begin
    sum = {1'b0, wr_ofs} + (word_mode ? (LEN_W+1)'(2) : (LEN_W+1)'(1));
    if (!wr_acc)                wr_ofs_nxt = wr_ofs;
    else if (sum > {1'b0, bsz}) wr_ofs_nxt = bsz;
    else                        wr_ofs_nxt = sum[LEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ofs <= '0;
      wr_sel <= 1'b0;
    end else if (set_take) begin
      wr_ofs <= '0;
      if (dbl) wr_sel <= ~wr_sel;
    end else begin
      wr_ofs <= wr_ofs_nxt;
    end
  end
endmodule

// File: rtl/inep_stsreg.sv
module inep_stsreg
  import inep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ep_en,
  input  logic       first,
  input  logic       dbl,
  input  logic       set_req,
  input  logic       ack_ret,
  output logic [1:0] sts,
  output logic       set_take
);
  logic [1:0] cnt, cnt_n;

  always_comb begin
    if (sts == BS_EMPTY)    cnt = 2'd0;
    else if (sts == BS_ONE) cnt = 2'd1;
    else                    cnt = dbl ? 2'd2 : 2'd1;
    set_take = set_req && (sts != BS_FULL);
    cnt_n    = cnt + {1'b0, set_take} - {1'b0, ack_ret};
  end

  always_ff @(posedge clk) begin
    if (rst || !ep_en) sts <= BS_FULL;
    else if (first)    sts <= BS_EMPTY;
    else               sts <= code_of(cnt_n, dbl);
  end
endmodule

// File: rtl/inep_txseq.sv
module inep_txseq #(
  parameter int LEN_W  = 11,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cont,
  input  logic              dbl,
  input  logic [LEN_W-1:0]  maxp,
  input  logic [LEN_W-1:0]  bsz,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              set_take,
  input  logic [LEN_W-1:0]  set_len,
  input  logic              wr_sel,
  input  logic              tx_go,
  input  logic              req_go,
  output logic              ack_ret,
  output logic              pkt_vld,
  output logic [LEN_W-1:0]  pkt_len,
  output logic [ADDR_W-1:0] pkt_addr
);
  logic [LEN_W-1:0] len_q [2];
  logic             rd_sel;
  logic [LEN_W-1:0] rd_ofs, rem, chunk;
  logic             last;

  for (genvar b = 0; b < 2; b++) begin : g_len
    always_ff @(posedge clk) begin
      if (rst || clr)                     len_q[b] <= '0;
      else if (set_take && (wr_sel == b)) len_q[b] <= set_len;
    end
  end

  always_comb begin
    chunk   = (rem > maxp) ? maxp : rem;
    last    = !cont || (rem <= maxp);
    ack_ret = tx_go && last;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_sel <= 1'b0;
      rd_ofs <= '0;
      rem    <= '0;
    end else begin
      if (set_take && cont) begin
        rem    <= set_len;
        rd_ofs <= '0;
      end
      if (tx_go) begin
        if (last) begin
          rd_ofs <= '0;
          if (dbl) rd_sel <= ~rd_sel;
        end else begin
          rem    <= rem - maxp;
          rd_ofs <= rd_ofs + maxp;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_vld  <= 1'b0;
      pkt_len  <= '0;
      pkt_addr <= '0;
    end else begin
      pkt_vld <= req_go;
      if (req_go) begin
        pkt_len  <= cont ? chunk : len_q[rd_sel];
        pkt_addr <= base_addr + ADDR_W'(rd_sel ? bsz : '0) + ADDR_W'(rd_ofs);
      end
    end
  end
endmodule

// File: rtl/inep_buf_tracker.sv
module inep_buf_tracker
  import inep_pkg::*;
#(
  parameter int UNIT_W     = 4,
  parameter int UNIT_SHIFT = 6,
  parameter int ADDR_W     = 12,
  localparam int LEN_W     = UNIT_W + UNIT_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ep_en,
  input  logic              dbl_buf,
  input  logic              cont_mode,
  input  logic              auto_set,
  input  logic              word_mode,
  input  logic [UNIT_W-1:0] buf_units,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  maxp,
  input  logic              cpu_wr,
  input  logic              set_rdy,
  input  logic              tx_ack,
  input  logic              pkt_req,
  output logic [1:0]        sts,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              pkt_vld,
  output logic [LEN_W-1:0]  pkt_len,
  output logic [ADDR_W-1:0] pkt_addr
);
  logic             en_q, first, active, dbl_eff;
  logic [LEN_W-1:0] bsz, target, wr_ofs, wr_ofs_nxt;
  logic             wr_sel, wr_acc, auto_hit, set_req, set_take, ack_ret;
  logic             has_data;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= ep_en;
  end

  always_comb begin
    first    = ep_en && !en_q;
    active   = ep_en && en_q;
    dbl_eff  = dbl_buf && !cont_mode;
    has_data = (sts != BS_EMPTY);
    bsz      = (LEN_W'(buf_units) + LEN_W'(1)) << UNIT_SHIFT;
    target   = cont_mode ? bsz : maxp;
    wr_acc   = cpu_wr && active && !sts[1] && (wr_ofs < bsz);
    auto_hit = auto_set && wr_acc && (wr_ofs_nxt >= target);
    set_req  = (set_rdy || auto_hit) && active;
    wr_addr  = base_addr + ADDR_W'(wr_sel ? bsz : '0) + ADDR_W'(wr_ofs);
  end

  inep_wrptr #(.LEN_W(LEN_W)) u_wr (
    .clk(clk), .rst(rst), .clr(!active), .wr_acc(wr_acc),
    .word_mode(word_mode), .bsz(bsz), .set_take(set_take), .dbl(dbl_eff),
    .wr_ofs(wr_ofs), .wr_ofs_nxt(wr_ofs_nxt), .wr_sel(wr_sel)
  );

  inep_stsreg u_st (
    .clk(clk), .rst(rst), .ep_en(ep_en), .first(first), .dbl(dbl_eff),
    .set_req(set_req), .ack_ret(ack_ret), .sts(sts), .set_take(set_take)
  );

  inep_txseq #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_tx (
    .clk(clk), .rst(rst), .clr(!active), .cont(cont_mode), .dbl(dbl_eff),
    .maxp(maxp), .bsz(bsz), .base_addr(base_addr), .set_take(set_take),
    .set_len(wr_ofs_nxt), .wr_sel(wr_sel),
    .tx_go(tx_ack && active && has_data),
    .req_go(pkt_req && active && has_data),
    .ack_ret(ack_ret), .pkt_vld(pkt_vld), .pkt_len(pkt_len), .pkt_addr(pkt_addr)
  );
endmodule

// File: rtl/inep_buf_tracker_chk.sv
module inep_buf_tracker_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ep_en,
  input logic              dbl_buf,
  input logic              cont_mode,
  input logic              cpu_wr,
  input logic              set_rdy,
  input logic              tx_ack,
  input logic              pkt_req,
  input logic [1:0]        sts,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              pkt_vld
);
  logic en_seen, act;

  always_ff @(posedge clk) begin
    if (rst) en_seen <= 1'b0;
    else     en_seen <= ep_en;
  end
  assign act = ep_en && en_seen;

  // R1
  dis_full_chk: assert property (@(posedge clk) disable iff (rst)
    !ep_en |=> sts == 2'b11);
  // R1
  en_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (ep_en && !en_seen) |=> sts == 2'b00);
  // R2
  blk_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (act && sts[1]) |=> $stable(wr_addr));
  // R4
  sgl_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (act && !dbl_buf && !cont_mode && sts == 2'b11 && tx_ack) |=> sts == 2'b00);
  // R5
  dbl_set_chk: assert property (@(posedge clk) disable iff (rst)
    (act && dbl_buf && !cont_mode && sts == 2'b00 && set_rdy && !tx_ack) |=> sts == 2'b01);
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act && sts == 2'b11 && !tx_ack) |=> sts == 2'b11);
  // R7
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (act && sts == 2'b00 && !set_rdy && !cpu_wr) |=> sts == 2'b00);
  // R10
  nodata_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_req && (!act || sts == 2'b00)) |=> !pkt_vld);
  // R5
  code_chk: assert property (@(posedge clk) disable iff (rst)
    sts != 2'b10);
endmodule

bind inep_buf_tracker inep_buf_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ep_en(ep_en), .dbl_buf(dbl_buf), .cont_mode(cont_mode),
  .cpu_wr(cpu_wr), .set_rdy(set_rdy), .tx_ack(tx_ack), .pkt_req(pkt_req),
  .sts(sts), .wr_addr(wr_addr), .pkt_vld(pkt_vld)
);

// File: tb/inep_buf_tracker_tb_top.sv
`timescale 1ns/1ps
module inep_buf_tracker_tb_top;
  localparam int UNIT_W = 4;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = UNIT_W + 6 + 1;
  localparam int BASE   = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, ep_en, dbl_buf, cont_mode, auto_set, word_mode;
  logic [UNIT_W-1:0] buf_units;
  logic [ADDR_W-1:0] base_addr;
  logic [LEN_W-1:0]  maxp;
  logic cpu_wr, set_rdy, tx_ack, pkt_req;
  logic [1:0] sts;
  logic [ADDR_W-1:0] wr_addr, pkt_addr;
  logic pkt_vld;
  logic [LEN_W-1:0] pkt_len;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  inep_buf_tracker #(.UNIT_W(UNIT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .ep_en(ep_en), .dbl_buf(dbl_buf), .cont_mode(cont_mode),
    .auto_set(auto_set), .word_mode(word_mode), .buf_units(buf_units),
    .base_addr(base_addr), .maxp(maxp), .cpu_wr(cpu_wr), .set_rdy(set_rdy),
    .tx_ack(tx_ack), .pkt_req(pkt_req), .sts(sts), .wr_addr(wr_addr),
    .pkt_vld(pkt_vld), .pkt_len(pkt_len), .pkt_addr(pkt_addr)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin cpu_wr = 1; tick(); end
    cpu_wr = 0;
  endtask

  task automatic do_set();
    set_rdy = 1; tick(); set_rdy = 0;
  endtask

  task automatic do_ack();
    tx_ack = 1; tick(); tx_ack = 0;
  endtask

  task automatic query(output int v, output int l, output int a);
    pkt_req = 1; tick(); pkt_req = 0;
    v = pkt_vld; l = pkt_len; a = pkt_addr;
  endtask

  task automatic restart(input bit d, input bit c, input bit au, input bit wm,
                         input int units, input int mp);
    ep_en = 0; dbl_buf = d; cont_mode = c; auto_set = au; word_mode = wm;
    buf_units = UNIT_W'(units); maxp = LEN_W'(mp);
    tick(); tick();
    check("R1 disabled status", sts, 3);
    ep_en = 1; tick();
    check("R1 enable clears status", sts, 0);
    check("R1 write pointer at base", wr_addr, BASE);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int v, l, a, fill, npk, rem, exp_len;
    int sl[7] = '{0, 1, 7, 8, 33, 64, 70};
    int da[3] = '{1, 8, 64};
    int db[3] = '{2, 0, 64};
    int dc[3] = '{3, 64, 5};
    int mps[4] = '{8, 10, 64, 3};
    int dls[3] = '{64, 30, 0};

    rst = 1; ep_en = 0; dbl_buf = 0; cont_mode = 0; auto_set = 0; word_mode = 0;
    buf_units = '0; base_addr = ADDR_W'(BASE); maxp = LEN_W'(8);
    cpu_wr = 0; set_rdy = 0; tx_ack = 0; pkt_req = 0;
    tick(); tick(); tick();
    check("R1 status in reset", sts, 3);
    rst = 0; tick();
    check("R1 status after reset, disabled", sts, 3);

    // single buffer sweep over fill lengths (R2 R3 R4 R6 R7 R10)
    foreach (sl[i]) begin
      restart(0, 0, 0, 0, 0, 8);
      fill = (sl[i] > 64) ? 64 : sl[i];
      write_n(sl[i]);
      check("R3 write offset capped at region", wr_addr, BASE + fill);
      do_set();
      check("R4 set-ready gives 11", sts, 3);
      write_n(3);
      check("R2 writes blocked at 11", wr_addr, BASE);
      do_set();
      check("R6 set-ready at 11 ignored", sts, 3);
      query(v, l, a);
      check("R10 descriptor valid", v, 1);
      check("R6 stored length kept", l, fill);
      check("R10 descriptor address", a, BASE);
      do_ack();
      check("R4 ack gives 00", sts, 0);
      do_ack();
      check("R7 ack at 00 ignored", sts, 0);
      query(v, l, a);
      check("R10 no descriptor when empty", v, 0);
    end

    // word access mode (R2)
    restart(0, 0, 0, 1, 0, 8);
    write_n(5);
    check("R2 word write step", wr_addr, BASE + 10);
    write_n(40);
    check("R3 word writes capped", wr_addr, BASE + 64);

    // double buffer (R3 R5 R11)
    foreach (da[i]) begin
      restart(1, 0, 0, 0, 1, 8);
      write_n(da[i]);
      do_set();
      check("R5 first set gives 01", sts, 1);
      check("R3 second region base", wr_addr, BASE + 128);
      write_n(db[i]);
      do_set();
      check("R5 second set gives 11", sts, 3);
      query(v, l, a);
      check("R5 oldest length", l, da[i]);
      check("R5 oldest address", a, BASE);
      do_ack();
      check("R5 ack from 11 gives 01", sts, 1);
      query(v, l, a);
      check("R5 second length", l, db[i]);
      check("R3 second address", a, BASE + 128);
      write_n(dc[i]);
      check("R5 reload into first region", wr_addr, BASE + dc[i]);
      set_rdy = 1; tx_ack = 1; tick(); set_rdy = 0; tx_ack = 0;
      check("R11 set with ack keeps 01", sts, 1);
      query(v, l, a);
      check("R11 new packet length", l, dc[i]);
      check("R11 new packet address", a, BASE);
      do_ack();
      check("R5 ack from 01 gives 00", sts, 0);
    end

    // continuous mode sweep (R8)
    foreach (mps[m]) begin
      foreach (dls[k]) begin
        restart(m % 2 == 1, 1, 0, 0, 0, mps[m]);
        write_n(dls[k]);
        do_set();
        check("R8 data set loaded gives 11", sts, 3);
        npk = (dls[k] == 0) ? 1 : (dls[k] + mps[m] - 1) / mps[m];
        for (int p = 0; p < npk; p++) begin
          rem = dls[k] - p * mps[m];
          exp_len = (rem > mps[m]) ? mps[m] : rem;
          query(v, l, a);
          check("R8 packet valid", v, 1);
          check("R8 packet length", l, exp_len);
          check("R8 packet address", a, BASE + p * mps[m]);
          do_ack();
          check("R8 status after ack", sts, (p == npk - 1) ? 0 : 3);
        end
      end
    end

    // auto-set (R9)
    restart(0, 0, 1, 0, 0, 8);
    write_n(7);
    check("R9 no auto-set below maxp", sts, 0);
    write_n(1);
    check("R9 auto-set at maxp", sts, 3);
    query(v, l, a);
    check("R9 auto-set length", l, 8);
    do_ack();
    write_n(5);
    check("R9 short fill waits", sts, 0);
    do_set();
    check("R9 explicit set of short packet", sts, 3);
    query(v, l, a);
    check("R9 short length", l, 5);
    restart(0, 1, 1, 0, 0, 10);
    write_n(63);
    check("R9 continuous no auto-set below region", sts, 0);
    write_n(1);
    check("R9 continuous auto-set at region size", sts, 3);
    query(v, l, a);
    check("R9 continuous first packet", l, 10);

    done = 1;
    finish_run();
  end
endmodule